// File: doc/BRIEF.md
# Two-Level Fully Associative Read Cache

This block sits between a requester and a slow word-addressed backing memory and serves read requests through two cache levels. The near level holds short lines of 4 words; the far level holds long lines of 16 words. Both levels are fully associative. Each line has its own tag comparator and a valid bit, and all comparators of a level work in the same cycle. When a level is full, the line that was used least recently is replaced.

A request enters on a valid/ready port as a byte address. Only one request is in flight at a time. A near-level hit answers one cycle after acceptance. A far-level hit answers after a fixed 5-cycle latency, and the aligned 4-word piece that holds the word is copied into the near level. When both levels miss, the block issues one burst read of the whole 16-word line. It fills the far line as the beats arrive, then copies the 4-word piece into the near level and answers. Each response carries the data word, a code for the level that supplied it, and the number of cycles it took.

Top module: `twolevel_rdcache`

## Requirements
- R1: After reset `req_ready` is 1 and `rsp_valid` and `mem_req` are 0. No line in either level is valid, so the first access to any address is answered from memory. A block never sits in more than one line of a level.
- R2: A near-level hit is answered in the cycle after acceptance. The response carries source code 0, a latency of 1, and the addressed 32-bit word.
- R3: A far-level hit is answered with source code 1, a latency of `L2_HIT_LAT` (5), and the addressed word. Its 16-byte piece is copied into the near level, so a later access to any word of that piece hits the near level.
- R4: A miss in both levels raises `mem_req` for exactly one cycle, with `mem_addr` set to the 64-byte aligned line base. The block then takes 16 beats on `mem_rvalid`, and beat i is word i of the line. It answers with source code 2 and the addressed word.
- R5: After a line has come from memory, an access to another 16-byte piece of the same 64-byte line misses the near level and hits the far level.
- R6: When the near level holds 4 blocks and a fifth is brought in, the least recently used block is dropped. A hit makes a block the most recently used.
- R7: When the far level holds 4 lines and a fifth is fetched, the least recently used line is dropped. Far-level hits and fills both count as uses.
- R8: `rsp_lat` equals the number of rising edges from the acceptance edge to the edge that raises `rsp_valid`, with both edges counted. `req_ready` stays low from a missed acceptance until the response. Each accepted request produces exactly one one-cycle response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Byte address of the word to read |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_data | output | DATA_W | Word read |
| rsp_src | output | 2 | 0 near level, 1 far level, 2 memory |
| rsp_lat | output | LAT_W | Cycles from acceptance to response |
| mem_req | output | 1 | One-cycle burst read start |
| mem_addr | output | ADDR_W | Line-aligned byte address of the burst |
| mem_rvalid | input | 1 | Burst beat present |
| mem_rdata | input | DATA_W | Burst beat word |

## Verification
The bench uses the default parameters: 4 lines per level, 4-word and 16-word lines, a far-level latency of 5, and 32-bit addresses and data. With only 4 lines per level, a short directed sequence is enough to fill each level and force a chosen eviction, so the recency order can be checked line by line. The random phase draws addresses from 8 far lines, twice the far capacity. It also varies the memory's delay before the first beat, so evictions happen often in both levels and the latency count is checked against several burst timings.

// File: rtl/tlc_pkg.sv
package tlc_pkg;
    typedef enum logic [1:0] {
        SRC_L1  = 2'd0,
        SRC_L2  = 2'd1,
        SRC_MEM = 2'd2
    } src_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_L2,
        ST_MEM,
        ST_L1FILL
    } st_e;
endpackage

// File: rtl/tlc_tag_store.sv
module tlc_tag_store #(
    parameter int LINES = 4,
    parameter int TAG_W = 28,
    localparam int WAY_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             hit,
    output logic [WAY_W-1:0] hit_way,
    output logic [LINES-1:0] match,
    output logic [WAY_W-1:0] victim_way,
    input  logic             upd_en,
    input  logic [WAY_W-1:0] upd_way,
    input  logic             upd_fill,
    input  logic [TAG_W-1:0] upd_tag
);
    typedef struct packed {
        logic [LINES-1:0][TAG_W-1:0] tag;
        logic [LINES-1:0]            vld;
        logic [LINES-1:0][WAY_W-1:0] age;
    } ts_t;

    ts_t s_q, s_d;

    // one comparator per line, all in parallel
    for (genvar i = 0; i < LINES; i++) begin : g_cmp
        assign match[i] = s_q.vld[i] && (s_q.tag[i] == lk_tag);
    end

    always_comb begin
        hit     = |match;
        hit_way = '0;
        for (int i = 0; i < LINES; i++) begin
            if (match[i]) hit_way = WAY_W'(i);
        end
    end

    // empty line first, otherwise the oldest one
    always_comb begin
        logic found;
        found      = 1'b0;
        victim_way = '0;
        for (int i = 0; i < LINES; i++) begin
            if (!found && !s_q.vld[i]) begin
                victim_way = WAY_W'(i);
                found      = 1'b1;
            end
        end
        if (!found) begin
            for (int i = 0; i < LINES; i++) begin
                if (s_q.age[i] == WAY_W'(LINES - 1)) victim_way = WAY_W'(i);
            end
        end
    end

    always_comb begin
        s_d = s_q;
        if (upd_en) begin
            if (upd_fill) begin
                s_d.tag[upd_way] = upd_tag;
                s_d.vld[upd_way] = 1'b1;
            end
            for (int i = 0; i < LINES; i++) begin
                if (WAY_W'(i) == upd_way) begin
                    s_d.age[i] = '0;
                end else if (s_q.age[i] < s_q.age[upd_way]) begin
                    s_d.age[i] = s_q.age[i] + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.tag <= '0;
            s_q.vld <= '0;
            for (int i = 0; i < LINES; i++) s_q.age[i] <= WAY_W'(i);
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/tlc_data_store.sv
module tlc_data_store #(
    parameter int LINES    = 4,
    parameter int WORDS    = 16,
    parameter int WR_WORDS = 1,
    parameter int DATA_W   = 32,
    localparam int WAY_W   = $clog2(LINES),
    localparam int CHUNKS  = WORDS / WR_WORDS,
    localparam int CH_W    = (CHUNKS > 1) ? $clog2(CHUNKS) : 1
) (
    input  logic                       clk,
    input  logic                       wr_en,
    input  logic [WAY_W-1:0]           wr_line,
    input  logic [CH_W-1:0]            wr_chunk,
    input  logic [WR_WORDS*DATA_W-1:0] wr_data,
    input  logic [WAY_W-1:0]           rd_line,
    output logic [WORDS*DATA_W-1:0]    rd_data
);
    logic [WORDS*DATA_W-1:0] mem_q [LINES];
    logic [WORDS*DATA_W-1:0] mem_d [LINES];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            for (int w = 0; w < WR_WORDS; w++) begin
                mem_d[wr_line][((CHUNKS > 1 ? int'(wr_chunk) : 0) * WR_WORDS + w) * DATA_W +: DATA_W]
                    = wr_data[w*DATA_W +: DATA_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign rd_data = mem_q[rd_line];
endmodule

// File: rtl/twolevel_rdcache.sv
module twolevel_rdcache
    import tlc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LAT_W      = 8,
    parameter int L1_LINES   = 4,
    parameter int L2_LINES   = 4,
    parameter int L1_WORDS   = 4,
    parameter int L2_WORDS   = 16,
    parameter int L2_HIT_LAT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [1:0]        rsp_src,
    output logic [LAT_W-1:0]  rsp_lat,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int BYTE_W   = $clog2(DATA_W / 8);
    localparam int L1_OFF_W = BYTE_W + $clog2(L1_WORDS);
    localparam int L2_OFF_W = BYTE_W + $clog2(L2_WORDS);
    localparam int L1_TAG_W = ADDR_W - L1_OFF_W;
    localparam int L2_TAG_W = ADDR_W - L2_OFF_W;
    localparam int L1_WAY_W = $clog2(L1_LINES);
    localparam int L2_WAY_W = $clog2(L2_LINES);
    localparam int WIDX_W   = $clog2(L2_WORDS);
    localparam int SUB_BITS = L1_WORDS * DATA_W;
    localparam logic [LAT_W-1:0] LAT_MAX = '1;

    typedef struct packed {
        st_e                 st;
        logic [ADDR_W-1:0]   addr;
        logic [LAT_W-1:0]    cnt;
        logic [WIDX_W-1:0]   wcnt;
        logic [L2_WAY_W-1:0] l2_way;
        logic                rsp_v;
        logic [DATA_W-1:0]   rsp_data;
        src_e                rsp_src;
        logic [LAT_W-1:0]    rsp_lat;
        logic                mem_req;
    } ctl_t;

    ctl_t q, n;

    logic                  l1_hit, l2_hit;
    logic [L1_WAY_W-1:0]   l1_hit_way, l1_victim, l1_upd_way;
    logic [L2_WAY_W-1:0]   l2_hit_way, l2_victim, l2_upd_way, l2_rd_line;
    logic [L1_LINES-1:0]   l1_match;
    logic [L2_LINES-1:0]   l2_match;
    logic                  l1_upd_en, l1_upd_fill, l2_upd_en, l2_upd_fill;
    logic                  l1_wr, l2_wr;
    logic [SUB_BITS-1:0]   l1_line, l1_sub;
    logic [L2_WORDS*DATA_W-1:0] l2_line;
    logic [DATA_W-1:0]     l1_word, sub_word;

    tlc_tag_store #(.LINES(L1_LINES), .TAG_W(L1_TAG_W)) u_l1_tags (
        .clk(clk), .rst_n(rst_n),
        .lk_tag(req_addr[ADDR_W-1:L1_OFF_W]),
        .hit(l1_hit), .hit_way(l1_hit_way), .match(l1_match),
        .victim_way(l1_victim),
        .upd_en(l1_upd_en), .upd_way(l1_upd_way), .upd_fill(l1_upd_fill),
        .upd_tag(q.addr[ADDR_W-1:L1_OFF_W])
    );

    tlc_tag_store #(.LINES(L2_LINES), .TAG_W(L2_TAG_W)) u_l2_tags (
        .clk(clk), .rst_n(rst_n),
        .lk_tag(q.addr[ADDR_W-1:L2_OFF_W]),
        .hit(l2_hit), .hit_way(l2_hit_way), .match(l2_match),
        .victim_way(l2_victim),
        .upd_en(l2_upd_en), .upd_way(l2_upd_way), .upd_fill(l2_upd_fill),
        .upd_tag(q.addr[ADDR_W-1:L2_OFF_W])
    );

    tlc_data_store #(.LINES(L1_LINES), .WORDS(L1_WORDS), .WR_WORDS(L1_WORDS), .DATA_W(DATA_W)) u_l1_data (
        .clk(clk), .wr_en(l1_wr), .wr_line(l1_victim), .wr_chunk(1'b0),
        .wr_data(l1_sub), .rd_line(l1_hit_way), .rd_data(l1_line)
    );

    tlc_data_store #(.LINES(L2_LINES), .WORDS(L2_WORDS), .WR_WORDS(1), .DATA_W(DATA_W)) u_l2_data (
        .clk(clk), .wr_en(l2_wr), .wr_line(q.l2_way), .wr_chunk(q.wcnt),
        .wr_data(mem_rdata), .rd_line(l2_rd_line), .rd_data(l2_line)
    );

    assign l1_word  = l1_line[int'(req_addr[L1_OFF_W-1:BYTE_W]) * DATA_W +: DATA_W];
    assign l1_sub   = l2_line[int'(q.addr[L2_OFF_W-1:L1_OFF_W]) * SUB_BITS +: SUB_BITS];
    assign sub_word = l1_sub[int'(q.addr[L1_OFF_W-1:BYTE_W]) * DATA_W +: DATA_W];

    always_comb begin
        n            = q;
        n.rsp_v      = 1'b0;
        n.mem_req    = 1'b0;
        l1_upd_en    = 1'b0;
        l1_upd_way   = l1_hit_way;
        l1_upd_fill  = 1'b0;
        l2_upd_en    = 1'b0;
        l2_upd_way   = l2_hit_way;
        l2_upd_fill  = 1'b0;
        l1_wr        = 1'b0;
        l2_wr        = 1'b0;
        l2_rd_line   = l2_hit_way;

        if (q.st != ST_IDLE && q.cnt != LAT_MAX) n.cnt = q.cnt + 1'b1;

        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (l1_hit) begin
                        l1_upd_en  = 1'b1;
                        n.rsp_v    = 1'b1;
                        n.rsp_data = l1_word;
                        n.rsp_src  = SRC_L1;
                        n.rsp_lat  = LAT_W'(1);
                    end else begin
                        n.addr = req_addr;
                        n.cnt  = LAT_W'(1);
                        n.st   = ST_L2;
                    end
                end
            end
            ST_L2: begin
                if (q.cnt == LAT_W'(L2_HIT_LAT - 1)) begin
                    if (l2_hit) begin
                        l2_upd_en   = 1'b1;
                        l1_upd_en   = 1'b1;
                        l1_upd_way  = l1_victim;
                        l1_upd_fill = 1'b1;
                        l1_wr       = 1'b1;
                        n.rsp_v     = 1'b1;
                        n.rsp_data  = sub_word;
                        n.rsp_src   = SRC_L2;
                        n.rsp_lat   = q.cnt + 1'b1;
                        n.st        = ST_IDLE;
                    end else begin
                        n.l2_way  = l2_victim;
                        n.wcnt    = '0;
                        n.mem_req = 1'b1;
                        n.st      = ST_MEM;
                    end
                end
            end
            ST_MEM: begin
                if (mem_rvalid) begin
                    l2_wr  = 1'b1;
                    n.wcnt = q.wcnt + 1'b1;
                    if (q.wcnt == WIDX_W'(L2_WORDS - 1)) begin
                        l2_upd_en   = 1'b1;
                        l2_upd_way  = q.l2_way;
                        l2_upd_fill = 1'b1;
                        n.st        = ST_L1FILL;
                    end
                end
            end
            ST_L1FILL: begin
                l2_rd_line  = q.l2_way;
                l1_upd_en   = 1'b1;
                l1_upd_way  = l1_victim;
                l1_upd_fill = 1'b1;
                l1_wr       = 1'b1;
                n.rsp_v     = 1'b1;
                n.rsp_data  = sub_word;
                n.rsp_src   = SRC_MEM;
                n.rsp_lat   = q.cnt + 1'b1;
                n.st        = ST_IDLE;
            end
            default: n.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign req_ready = (q.st == ST_IDLE);
    assign rsp_valid = q.rsp_v;
    assign rsp_data  = q.rsp_data;
    assign rsp_src   = q.rsp_src;
    assign rsp_lat   = q.rsp_lat;
    assign mem_req   = q.mem_req;
    assign mem_addr  = {q.addr[ADDR_W-1:L2_OFF_W], {L2_OFF_W{1'b0}}};
endmodule

// File: rtl/tlc_chk.sv
module tlc_chk #(
    parameter int ADDR_W     = 32,
    parameter int LAT_W      = 8,
    parameter int L1_LINES   = 4,
    parameter int L2_LINES   = 4,
    parameter int L2_WORDS   = 16,
    parameter int L2_HIT_LAT = 5,
    parameter int L2_OFF_W   = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_ready,
    input logic                rsp_valid,
    input logic [1:0]          rsp_src,
    input logic [LAT_W-1:0]    rsp_lat,
    input logic                mem_req,
    input logic [ADDR_W-1:0]   mem_addr,
    input logic [L1_LINES-1:0] l1_match,
    input logic [L2_LINES-1:0] l2_match
);
    // R1
    uniq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(l1_match) && $onehot0(l2_match));

    // R2
    near_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_src == 2'd0 |-> rsp_lat == LAT_W'(1));

    // R2
    near_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_src == 2'd0 |-> $past(req_valid && req_ready));

    // R3
    far_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_src == 2'd1 |-> rsp_lat == LAT_W'(L2_HIT_LAT));

    // R4
    burst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R4
    burst_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[L2_OFF_W-1:0] == '0);

    // R4
    mem_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_src == 2'd2 |-> rsp_lat > LAT_W'(L2_HIT_LAT + L2_WORDS));

    // R8
    busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready && !rsp_valid);
endmodule

bind twolevel_rdcache tlc_chk #(
    .ADDR_W(ADDR_W), .LAT_W(LAT_W), .L1_LINES(L1_LINES), .L2_LINES(L2_LINES),
    .L2_WORDS(L2_WORDS), .L2_HIT_LAT(L2_HIT_LAT), .L2_OFF_W(L2_OFF_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_src(rsp_src), .rsp_lat(rsp_lat),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .l1_match(l1_match), .l2_match(l2_match)
);

// File: tb/twolevel_rdcache_tb.sv
module twolevel_rdcache_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32, DW = 32, LATW = 8;
    localparam int L1N = 4, L2N = 4, L1W = 4, L2W = 16, L2LAT = 5;

    logic          clk = 1'b0;
    logic          rst_n, req_valid, req_ready, rsp_valid, mem_req, mem_rvalid;
    logic [AW-1:0] req_addr, mem_addr;
    logic [DW-1:0] rsp_data, mem_rdata;
    logic [1:0]    rsp_src;
    logic [LATW-1:0] rsp_lat;

    always #(CLK_PERIOD / 2) clk = ~clk;

    twolevel_rdcache #(
        .ADDR_W(AW), .DATA_W(DW), .LAT_W(LATW), .L1_LINES(L1N), .L2_LINES(L2N),
        .L1_WORDS(L1W), .L2_WORDS(L2W), .L2_HIT_LAT(L2LAT)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_src(rsp_src), .rsp_lat(rsp_lat), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    int checks = 0, errors = 0;
    bit done = 0;
    int last_gap = 0;
    logic [AW-1:0] cur_addr = '0;
    int l1q[$];
    int l2q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // backing memory: each word holds its own byte address
    initial begin
        mem_rvalid = 1'b0;
        mem_rdata  = '0;
        forever begin
            @(negedge clk);
            if (mem_req === 1'b1) begin
                chk(mem_addr == (cur_addr & 32'hffff_ffc0), "R4", "burst base",
                    mem_addr, cur_addr & 32'hffff_ffc0);
                last_gap = $urandom % 4;
                repeat (last_gap) @(negedge clk);
                for (int i = 0; i < L2W; i++) begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = mem_addr + DW'(4 * i);
                    @(negedge clk);
                end
                mem_rvalid = 1'b0;
            end
        end
    end

    // reference model: recency lists, most recent first
    function automatic int predict(input logic [AW-1:0] a);
        int b1 = int'(a >> 4);
        int b2 = int'(a >> 6);
        int f1 = -1, f2 = -1;
        foreach (l1q[i]) if (l1q[i] == b1) f1 = i;
        if (f1 >= 0) begin
            l1q.delete(f1);
            l1q.push_front(b1);
            return 0;
        end
        foreach (l2q[i]) if (l2q[i] == b2) f2 = i;
        if (f2 >= 0) l2q.delete(f2);
        l2q.push_front(b2);
        if (l2q.size() > L2N) void'(l2q.pop_back());
        l1q.push_front(b1);
        if (l1q.size() > L1N) void'(l1q.pop_back());
        return (f2 >= 0) ? 1 : 2;
    endfunction

    task automatic do_req(input logic [AW-1:0] a, input string label);
        int    esrc, elat, n;
        string tag;
        esrc = predict(a);
        if (label != "") tag = label;
        else tag = (esrc == 0) ? "R2" : (esrc == 1) ? "R3" : "R4";
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        cur_addr  = a;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n = 1;
        if (esrc != 0) chk(req_ready == 1'b0 && rsp_valid == 1'b0, "R8", "busy after miss",
                           {req_ready, rsp_valid}, 0);
        while (rsp_valid !== 1'b1 && n < 200) begin
            @(negedge clk);
            n++;
        end
        elat = (esrc == 0) ? 1 : (esrc == 1) ? L2LAT : L2LAT + L2W + 1 + last_gap;
        chk(rsp_src == 2'(esrc), tag, "source", rsp_src, esrc);
        chk(rsp_data == (a & 32'hffff_fffc), tag, "data", rsp_data, a & 32'hffff_fffc);
        chk(int'(rsp_lat) == elat, tag, "latency field", rsp_lat, elat);
        chk(n == elat, "R8", "measured latency", n, elat);
        @(negedge clk);
        chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R8", "single response",
            {rsp_valid, req_ready}, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_addr  = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_req == 1'b0, "R1", "reset outputs",
            {req_ready, rsp_valid, mem_req}, 3'b100);

        do_req(32'h1000, "R1");   // cold miss in both levels
        do_req(32'h1004, "R2");   // same 16-byte piece
        do_req(32'h1010, "R5");   // other piece of the fetched line
        do_req(32'h1014, "R3");   // copied piece now near
        do_req(32'h1020, "R5");
        do_req(32'h1030, "R5");
        do_req(32'h1000, "R6");   // refresh, near level full
        do_req(32'h1040, "R4");   // evicts piece 0x1010 from near level
        do_req(32'h1010, "R6");   // must come from far level
        do_req(32'h1008, "R6");   // refreshed piece survived
        do_req(32'h2000, "R7");
        do_req(32'h3000, "R7");   // far level full
        do_req(32'h1050, "R7");   // refresh line 0x1040
        do_req(32'h4000, "R7");   // evicts line 0x1000
        do_req(32'h1020, "R7");   // evicted line back from memory
        do_req(32'h1060, "R7");   // refreshed line still present

        for (int k = 0; k < 150; k++) begin
            logic [AW-1:0] a;
            a = 32'h8000 + AW'(($urandom % 8) * 64) + AW'(($urandom % 16) * 4);
            do_req(a, "");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule